// File: doc/BRIEF.md
# Interrupt Entry Sequencer with Return-Address Stack

This block sits beside the fetch logic of a small word-addressed DSP core. At every instruction boundary the core tells it which opcode just completed, the address it is about to fetch next, and whether the completed instruction pushes or pops the return stack. The block keeps a single sticky interrupt-pending flag, fed by the rising edge of an external request line. It also holds the interrupt mask and overflow-mode bits, which it updates from the enable, disable and overflow-mode opcodes. From these it decides, before the next fetch, whether to enter the interrupt routine.

On entry the block raises a one-cycle redirect strobe with the vector address. It clears the pending flag, sets the mask, and pushes the interrupted fetch address onto a four-level return stack. It then holds fetch for the remaining cycles of the three-cycle entry cost. The return stack is a plain shift register with no pointer. A push discards the oldest level. A pop slides every level toward the top and leaves a copy of the bottom level behind. The top level is always visible as the pop data.

Top module: `irq_stack_seq`

## Requirements
- R1: After reset the status word reads 0x7EFE (bit 15 overflow = 0, bit 14 overflow mode = 1, bit 13 mask = 1, bits 12..9 and 7..1 constant 1, bits 8 and 0 = 0). Redirect and fetch hold are low and the stack reads zero.
- R2: A 0-to-1 transition on the request line sets the pending flag. Lowering the line does not clear it. The flag stays set until an entry is taken.
- R3: Entry is considered only on a cycle with the instruction-done strobe. It is refused while the mask, as left by the completed instruction, is 1.
- R4: Entry is refused at a boundary whose completed opcode has high byte 0x6D, or top three bits 100, or equals 0x7F82. A pending request is then taken at the next eligible boundary.
- R5: An entry asserts the redirect strobe with new PC 0x002 in the boundary cycle. It clears the pending flag, sets the mask bit, and pushes the current fetch address.
- R6: Fetch hold is high for the two cycles that follow the redirect cycle, giving a three-cycle entry.
- R7: Opcode 0x7F82 clears the mask bit and opcode 0x7F81 sets it. A 0x7F81 boundary with a pending request does not enter.
- R8: Opcode 0x7F8B sets the overflow-mode bit (status bit 14) and opcode 0x7F8A clears it.
- R9: The stack holds four levels. A push places the new value on top and discards the oldest level.
- R10: A pop moves every level one place toward the top, and the bottom level keeps its value.
- R11: Every value written to the stack is cut to its low 12 bits.
- R12: Several rising edges before an entry merge into one pending request and produce exactly one entry.
- R13: When an instruction push and an entry fall in the same cycle, the instruction's value goes on first. The interrupted fetch address ends on top.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 1 | External interrupt request level |
| instr_done | input | 1 | Instruction boundary strobe; the fields below are valid |
| last_op | input | 16 | Opcode of the instruction that just completed |
| pc_cur | input | 12 | Address of the next instruction to fetch |
| push_req | input | 1 | Completed instruction pushes push_data |
| push_data | input | 16 | Value to push (low 12 bits kept) |
| pop_req | input | 1 | Completed instruction pops the stack |
| redirect | output | 1 | Interrupt entry taken this cycle |
| pc_new | output | 12 | Vector address while redirect is high, else zero |
| hold_fetch | output | 1 | Fetch stalled during the remaining entry cycles |
| pop_data | output | 12 | Current top of the return stack |
| status_word | output | 16 | Status view with mask and overflow-mode bits |

## Verification
The assertions watch the rules that hold cycle by cycle. These are the opcode blocking of entry, the mask gate, the vector value, the hold that follows a redirect, the stickiness of the pending flag, and the push and pop motion of the stack's top and bottom levels. Only the bench scenarios show the sequences. These are a request deferred across a blocking opcode and served later, merged requests giving one entry, the ordering of two pushes in one cycle, the bottom-level duplication after several pops, and the reset status word.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    localparam logic [15:0] OP_INT_ON   = 16'h7F82;
    localparam logic [15:0] OP_INT_OFF  = 16'h7F81;
    localparam logic [15:0] OP_OVM_ON   = 16'h7F8B;
    localparam logic [15:0] OP_OVM_OFF  = 16'h7F8A;
    localparam logic [7:0]  OP_MUL_HI   = 8'h6D;
    localparam logic [2:0]  OP_MULK_TOP = 3'b100;

    localparam int ST_OVM_BIT  = 14;
    localparam int ST_MASK_BIT = 13;
    localparam logic [15:0] ST_FIXED_ONES = 16'h1EFE;

    // Opcodes after which entry must wait one more instruction
    function automatic logic op_blocks_entry(input logic [15:0] op);
        return (op[15:8] == OP_MUL_HI) ||
               (op[15:13] == OP_MULK_TOP) ||
               (op == OP_INT_ON);
    endfunction

endpackage

// File: rtl/irq_pend_flag.sv
module irq_pend_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic clear,
    output logic pending
);
    typedef struct packed {
        logic req_prev;
        logic pend;
    } pend_state_t;

    pend_state_t st_d, st_q;
    logic rise;

    always_comb begin
        st_d          = st_q;
        rise          = req && !st_q.req_prev;
        st_d.req_prev = req;
        if (clear)
            st_d.pend = 1'b0;
        if (rise)
            st_d.pend = 1'b1;   // a fresh edge in the service cycle survives
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign pending = st_q.pend;

    p_edge_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !st_q.req_prev) |=> pending);

    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !clear) |=> pending);

endmodule

// File: rtl/irq_entry_gate.sv
module irq_entry_gate
    import irq_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        instr_done,
    input  logic [15:0] last_op,
    input  logic        pending,
    output logic        take,
    output logic        mask_bit,
    output logic        ovm_bit
);
    typedef struct packed {
        logic mask;
        logic ovm;
    } mode_t;

    mode_t md_d, md_q;
    logic  mask_after_op;

    always_comb begin
        md_d = md_q;
        if (instr_done) begin
            if (last_op == OP_INT_ON)  md_d.mask = 1'b0;
            if (last_op == OP_INT_OFF) md_d.mask = 1'b1;
            if (last_op == OP_OVM_ON)  md_d.ovm  = 1'b1;
            if (last_op == OP_OVM_OFF) md_d.ovm  = 1'b0;
        end
        mask_after_op = md_d.mask;
        take = instr_done && pending && !mask_after_op && !op_blocks_entry(last_op);
        if (take)
            md_d.mask = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            md_q <= '{mask: 1'b1, ovm: 1'b1};
        else
            md_q <= md_d;
    end

    assign mask_bit = md_q.mask;
    assign ovm_bit  = md_q.ovm;

    p_mul_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_done && last_op[15:8] == 8'h6D) |-> !take);

    p_mulk_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_done && last_op[15:13] == 3'b100) |-> !take);

    p_mask_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_bit && last_op != 16'h7F82) |-> !take);

    p_disable_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_done && last_op == 16'h7F81) |-> !take);

    p_mask_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> mask_bit);

endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack #(
    parameter int AW    = 12,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop,
    input  logic          push_a,
    input  logic [AW-1:0] data_a,
    input  logic          push_b,
    input  logic [AW-1:0] data_b,
    output logic [AW-1:0] top,
    output logic [AW-1:0] bottom
);
    localparam int TOP = DEPTH - 1;

    typedef struct packed {
        logic [DEPTH-1:0][AW-1:0] lvl;
    } stk_t;

    stk_t stk_d, stk_q;

    // Order inside one cycle: pop, then the instruction push, then the entry push
    always_comb begin
        stk_t work;
        work = stk_q;
        if (pop) begin
            for (int i = TOP; i > 0; i--)
                work.lvl[i] = stk_q.lvl[i-1];
        end
        if (push_a) begin
            for (int i = 0; i < TOP; i++)
                work.lvl[i] = work.lvl[i+1];
            work.lvl[TOP] = data_a;
        end
        if (push_b) begin
            for (int i = 0; i < TOP; i++)
                work.lvl[i] = work.lvl[i+1];
            work.lvl[TOP] = data_b;
        end
        stk_d = work;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            stk_q <= '0;
        else
            stk_q <= stk_d;
    end

    assign top    = stk_q.lvl[TOP];
    assign bottom = stk_q.lvl[0];

    p_push_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push_a && !push_b && !pop) |=> top == $past(data_a));

    p_pop_bottom_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push_a && !push_b) |=> bottom == $past(bottom));

    p_entry_last_r13: assert property (@(posedge clk) disable iff (!rst_n)
        push_b |=> top == $past(data_b));

endmodule

// File: rtl/irq_stack_seq.sv
module irq_stack_seq
    import irq_seq_pkg::*;
#(
    parameter int          PC_W         = 12,
    parameter int          STACK_DEPTH  = 4,
    parameter int          ENTRY_CYCLES = 3,
    parameter logic [11:0] VECTOR       = 12'h002
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            irq_req,
    input  logic            instr_done,
    input  logic [15:0]     last_op,
    input  logic [PC_W-1:0] pc_cur,
    input  logic            push_req,
    input  logic [15:0]     push_data,
    input  logic            pop_req,
    output logic            redirect,
    output logic [PC_W-1:0] pc_new,
    output logic            hold_fetch,
    output logic [PC_W-1:0] pop_data,
    output logic [15:0]     status_word
);
    localparam int HOLD_W = $clog2(ENTRY_CYCLES) + 1;
    localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(ENTRY_CYCLES - 1);

    typedef struct packed {
        logic [HOLD_W-1:0] hold_cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    logic            pending;
    logic            take;
    logic            mask_bit;
    logic            ovm_bit;
    logic [PC_W-1:0] stack_bottom;
    logic            unused_hi;

    assign unused_hi = ^push_data[15:PC_W];

    irq_pend_flag u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (irq_req),
        .clear   (take),
        .pending (pending)
    );

    irq_entry_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .instr_done (instr_done),
        .last_op    (last_op),
        .pending    (pending),
        .take       (take),
        .mask_bit   (mask_bit),
        .ovm_bit    (ovm_bit)
    );

    ret_addr_stack #(
        .AW    (PC_W),
        .DEPTH (STACK_DEPTH)
    ) u_stack (
        .clk    (clk),
        .rst_n  (rst_n),
        .pop    (instr_done && pop_req),
        .push_a (instr_done && push_req),
        .data_a (push_data[PC_W-1:0]),
        .push_b (take),
        .data_b (pc_cur),
        .top    (pop_data),
        .bottom (stack_bottom)
    );

    always_comb begin
        seq_d = seq_q;
        if (take)
            seq_d.hold_cnt = HOLD_LOAD;
        else if (seq_q.hold_cnt != '0)
            seq_d.hold_cnt = seq_q.hold_cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            seq_q <= '0;
        else
            seq_q <= seq_d;
    end

    assign redirect   = take;
    assign pc_new     = take ? VECTOR[PC_W-1:0] : '0;
    assign hold_fetch = (seq_q.hold_cnt != '0);

    always_comb begin
        status_word              = ST_FIXED_ONES;
        status_word[ST_OVM_BIT]  = ovm_bit;
        status_word[ST_MASK_BIT] = mask_bit;
    end

    p_vector_r5: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> (pc_new == 12'h002));

    p_hold_after_r6: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> hold_fetch);

    p_no_entry_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_done |-> !redirect);

    p_push_pc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> pop_data == $past(pc_cur));

endmodule

// File: tb/irq_stack_seq_test.sv
`timescale 1ns/100ps
module irq_stack_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_req = 1'b0;
    logic        instr_done = 1'b0;
    logic [15:0] last_op = 16'h0000;
    logic [11:0] pc_cur = 12'h000;
    logic        push_req = 1'b0;
    logic [15:0] push_data = 16'h0000;
    logic        pop_req = 1'b0;
    logic        redirect;
    logic [11:0] pc_new;
    logic        hold_fetch;
    logic [11:0] pop_data;
    logic [15:0] status_word;

    int checks = 0;
    int fails  = 0;
    logic c_redir;
    logic [11:0] c_pcnew;

    localparam logic [15:0] NOP  = 16'h7F80;
    localparam logic [15:0] EINT = 16'h7F82;
    localparam logic [15:0] DINT = 16'h7F81;

    always #2.5 clk = ~clk;

    irq_stack_seq uut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .instr_done(instr_done),
        .last_op(last_op), .pc_cur(pc_cur), .push_req(push_req),
        .push_data(push_data), .pop_req(pop_req), .redirect(redirect),
        .pc_new(pc_new), .hold_fetch(hold_fetch), .pop_data(pop_data),
        .status_word(status_word)
    );

    // push, pop, data, expected top after the step
    localparam logic [29:0] STK_VEC [9] = '{
        {1'b1, 1'b0, 16'h0111, 12'h111},
        {1'b1, 1'b0, 16'hF222, 12'h222},
        {1'b1, 1'b0, 16'h0333, 12'h333},
        {1'b1, 1'b0, 16'h0444, 12'h444},
        {1'b1, 1'b0, 16'h0555, 12'h555},
        {1'b0, 1'b1, 16'h0000, 12'h444},
        {1'b0, 1'b1, 16'h0000, 12'h333},
        {1'b0, 1'b1, 16'h0000, 12'h222},
        {1'b0, 1'b1, 16'h0000, 12'h222}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive one cycle from a negedge; capture combinational outputs before the edge
    task automatic step(input logic done, input logic [15:0] op, input logic [11:0] pc,
                        input logic psh, input logic [15:0] pd, input logic pp, input logic irq);
        instr_done = done; last_op = op; pc_cur = pc;
        push_req = psh; push_data = pd; pop_req = pp; irq_req = irq;
        #1;
        c_redir = redirect;
        c_pcnew = pc_new;
        @(posedge clk);
        @(negedge clk);
        instr_done = 1'b0; push_req = 1'b0; pop_req = 1'b0;
    endtask

    task automatic boundary(input logic [15:0] op, input logic [11:0] pc);
        step(1'b1, op, pc, 1'b0, 16'h0, 1'b0, 1'b0);
    endtask

    task automatic irq_pulse();
        step(1'b0, NOP, 12'h0, 1'b0, 16'h0, 1'b0, 1'b1);
        chk("R3 no entry without boundary", {31'b0, c_redir}, 32'd0);
        step(1'b0, NOP, 12'h0, 1'b0, 16'h0, 1'b0, 1'b0);
    endtask

    initial begin
        #100000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        // R1 reset state
        chk("R1 status", {16'b0, status_word}, 32'h7EFE);
        chk("R1 redirect", {31'b0, redirect}, 32'd0);
        chk("R1 hold", {31'b0, hold_fetch}, 32'd0);
        chk("R1 stack", {20'b0, pop_data}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 R10 R11 stack vectors
        for (int i = 0; i < 9; i++) begin
            step(1'b1, NOP, 12'h0, STK_VEC[i][29], STK_VEC[i][27:12], STK_VEC[i][28], 1'b0);
            chk(STK_VEC[i][29] ? "R9 R11 push top" : "R10 pop top",
                {20'b0, pop_data}, {20'b0, STK_VEC[i][11:0]});
        end

        // R3 masked after reset
        irq_pulse();
        boundary(NOP, 12'h100);
        chk("R3 masked no entry", {31'b0, c_redir}, 32'd0);
        // R4 R7 enable blocks this boundary
        boundary(EINT, 12'h101);
        chk("R4 enable blocks", {31'b0, c_redir}, 32'd0);
        chk("R7 mask cleared", {16'b0, status_word}, 32'h5EFE);
        boundary(16'h6D05, 12'h102);
        chk("R4 multiply blocks", {31'b0, c_redir}, 32'd0);
        boundary(16'h8123, 12'h103);
        chk("R4 multiply-immediate blocks", {31'b0, c_redir}, 32'd0);
        // R2 R5 sticky request taken now
        boundary(NOP, 12'h345);
        chk("R2 R5 redirect", {31'b0, c_redir}, 32'd1);
        chk("R5 vector", {20'b0, c_pcnew}, 32'h002);
        chk("R5 mask set", {16'b0, status_word}, 32'h7EFE);
        chk("R5 pc pushed", {20'b0, pop_data}, 32'h345);
        chk("R6 hold 1", {31'b0, hold_fetch}, 32'd1);
        step(1'b0, NOP, 12'h0, 1'b0, 16'h0, 1'b0, 1'b0);
        chk("R6 hold 2", {31'b0, hold_fetch}, 32'd1);
        step(1'b0, NOP, 12'h0, 1'b0, 16'h0, 1'b0, 1'b0);
        chk("R6 hold end", {31'b0, hold_fetch}, 32'd0);
        // R5 pending cleared
        boundary(EINT, 12'h010);
        boundary(NOP, 12'h011);
        chk("R5 pending cleared", {31'b0, c_redir}, 32'd0);

        // R12 merged requests
        irq_pulse();
        irq_pulse();
        boundary(NOP, 12'h200);
        chk("R12 one entry", {31'b0, c_redir}, 32'd1);
        boundary(EINT, 12'h020);
        boundary(NOP, 12'h021);
        chk("R12 no second entry", {31'b0, c_redir}, 32'd0);

        // R7 disable at boundary wins
        irq_pulse();
        boundary(DINT, 12'h030);
        chk("R7 disable refuses", {31'b0, c_redir}, 32'd0);
        chk("R7 mask set", {16'b0, status_word}, 32'h7EFE);
        boundary(EINT, 12'h031);
        boundary(NOP, 12'h032);
        chk("R7 R2 later entry", {31'b0, c_redir}, 32'd1);

        // R13 push order with entry
        boundary(EINT, 12'h040);
        irq_pulse();
        step(1'b1, NOP, 12'hDEF, 1'b1, 16'h0ABC, 1'b0, 1'b0);
        chk("R13 entry", {31'b0, c_redir}, 32'd1);
        chk("R13 pc on top", {20'b0, pop_data}, 32'hDEF);
        step(1'b1, NOP, 12'h002, 1'b0, 16'h0, 1'b1, 1'b0);
        chk("R13 push below", {20'b0, pop_data}, 32'hABC);

        // R8 overflow mode
        boundary(16'h7F8A, 12'h050);
        chk("R8 mode clear", {16'b0, status_word}, 32'h3EFE);
        boundary(16'h7F8B, 12'h051);
        chk("R8 mode set", {16'b0, status_word}, 32'h7EFE);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule